// File: doc/BRIEF.md
# Conversion Result Threshold Monitor

This block watches a stream of conversion results as they are stored and raises a sticky flag when a programmed channel has produced enough results on a chosen side of a threshold. Each result arrives as a one-cycle valid strobe with a 12-bit value and a 5-bit channel number. Two independent compare units look at the same stream. Each unit has its own configuration word, its own hidden match counter and its own flag. The two flags form a shared status pair.

A unit counts only those results whose channel equals its selected channel. Each result that meets the condition adds one to the counter. A result that fails the condition sets the counter back to zero, so only an unbroken run of matches counts. When the run length reaches the programmed match count plus one, the flag sets and the counter is held at zero. It stays at zero until software clears the flag with a write-1 strobe. A single interrupt line is raised while any flag is set and that unit's interrupt enable is on.

Top module: `result_cmp_monitor`

## Requirements
- R1: After reset both flags and the interrupt output are 0.
- R2: The configuration word of unit i is `cmp_cfg[32*i +: 32]`, with these fields: bit 0 enable, bit 1 interrupt enable, bit 2 condition, bits 7:3 channel, bits 11:8 match count, bits 27:16 threshold. A result is evaluated only when enable is 1 and `res_ch` equals the channel field. Results on other channels leave the counter unchanged.
- R3: With condition 0, a result matches only when it is strictly less than the threshold. A result equal to the threshold does not match.
- R4: With condition 1, a result matches when it is greater than or equal to the threshold.
- R5: The flag sets in the cycle after the (N+1)-th consecutive match, where N is the match count field. N = 0 sets the flag on the first match.
- R6: A result on the selected channel that does not match resets the counter to 0.
- R7: A set flag stays set until `flag_clr[i]` is 1 for one cycle. While the flag is set, the counter is held at 0. Counting starts again from zero after the clear. A clear strobe takes priority over a set in the same cycle.
- R8: `irq` is 1 exactly when some flag is set and that unit's interrupt enable bit is 1.
- R9: Setting the enable bit to 0 resets the counter to 0.
- R10: The two units are independent. Activity in one unit never changes the other unit's counter or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | One-cycle strobe: a result is being stored |
| res_data | input | 12 | Result value |
| res_ch | input | 5 | Channel of the result |
| cmp_cfg | input | 64 | Configuration words, unit 0 in the low 32 bits |
| flag_clr | input | 2 | Write-1 clear strobes for the flags |
| cmp_flag | output | 2 | Sticky compare flags |
| irq | output | 1 | Compare interrupt request |

## Verification
The assertions assume three things about the inputs. The configuration words change only between clock edges. A clear strobe lasts one cycle. The channel number is valid whenever `res_vld` is high. The random stimulus draws channels from a small set that includes both selected channels and some non-selected ones. Result values are drawn close to the thresholds so that both sides of the condition, and the equality case, occur often. Enables, conditions and clears are changed only at the falling edge.

// File: rtl/result_cmp_monitor.sv
module result_cmp_monitor #(
  parameter int DW   = 12,
  parameter int CHW  = 5,
  parameter int MW   = 4,
  parameter int NCMP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_vld,
  input  logic [DW-1:0]        res_data,
  input  logic [CHW-1:0]       res_ch,
  input  logic [NCMP*32-1:0]   cmp_cfg,
  input  logic [NCMP-1:0]      flag_clr,
  output logic [NCMP-1:0]      cmp_flag,
  output logic                 irq
);
  logic [NCMP-1:0] irq_src;

  for (genvar i = 0; i < NCMP; i++) begin : g_unit
    logic [31:0]    cfg;
    logic           en, ie, cond, sel, pass, hit;
    logic [MW-1:0]  cnt, limit;
    logic [DW-1:0]  thr;

    assign cfg   = cmp_cfg[32*i +: 32];
    assign en    = cfg[0];
    assign ie    = cfg[1];
    assign cond  = cfg[2];
    assign limit = cfg[8 +: MW];
    assign thr   = cfg[16 +: DW];
    assign sel   = res_vld && (res_ch == cfg[3 +: CHW]);
    assign pass  = cond ? (res_data >= thr) : (res_data < thr);
    assign hit   = en && !cmp_flag[i] && sel && pass && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (!en || cmp_flag[i]) begin
        cnt <= '0;
      end else if (sel) begin
        if (!pass || hit) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cmp_flag[i] <= 1'b0;
      else if (flag_clr[i]) cmp_flag[i] <= 1'b0;
      else if (hit)         cmp_flag[i] <= 1'b1;
    end

    assign irq_src[i] = cmp_flag[i] && ie;
  end

  assign irq = |irq_src;
endmodule

// File: rtl/result_cmp_monitor_chk.sv
module result_cmp_monitor_chk #(
  parameter int DW   = 12,
  parameter int CHW  = 5,
  parameter int NCMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_vld,
  input logic [CHW-1:0]     res_ch,
  input logic [NCMP*32-1:0] cmp_cfg,
  input logic [NCMP-1:0]    flag_clr,
  input logic [NCMP-1:0]    cmp_flag,
  input logic               irq
);
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag == '0) |-> !irq); // R8

  for (genvar i = 0; i < NCMP; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag[i] && !flag_clr[i]) |=> cmp_flag[i]); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr[i] |=> !cmp_flag[i]); // R7
    AST_SET_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag[i]) |-> $past(res_vld && cmp_cfg[32*i] &&
                                   res_ch == cmp_cfg[32*i+3 +: CHW])); // R2
    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag[i] && cmp_cfg[32*i+1]) |-> irq); // R8
  end
endmodule

bind result_cmp_monitor result_cmp_monitor_chk #(.DW(DW), .CHW(CHW), .NCMP(NCMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch),
  .cmp_cfg(cmp_cfg), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .irq(irq)
);

// File: tb/result_cmp_monitor_tb.sv
module result_cmp_monitor_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        res_vld = 0;
  logic [11:0] res_data = 0;
  logic [4:0]  res_ch = 0;
  logic [63:0] cmp_cfg = 0;
  logic [1:0]  flag_clr = 0;
  logic [1:0]  cmp_flag;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_flag;
  logic [3:0] m_cnt [2];

  always #5 clk = ~clk;

  result_cmp_monitor u_dut (.*);

  function automatic logic [31:0] mk(input logic [11:0] thr, input logic [3:0] n,
                                     input logic [4:0] ch, input logic cond,
                                     input logic ie, input logic en);
    mk = {4'h0, thr, 4'h0, n, ch, cond, ie, en};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] c;
        logic mt, st;
        c = cmp_cfg[32*i +: 32];
        mt = c[2] ? (res_data >= c[27:16]) : (res_data < c[27:16]);
        st = 0;
        if (!c[0] || m_flag[i]) m_cnt[i] = 0;
        else if (res_vld && res_ch == c[7:3]) begin
          if (!mt) m_cnt[i] = 0;
          else if (m_cnt[i] == c[11:8]) begin st = 1; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
        if (flag_clr[i]) m_flag[i] = 0;
        else if (st) m_flag[i] = 1;
      end
    end
  end

  function automatic logic m_irq();
    m_irq = (m_flag[0] && cmp_cfg[1]) || (m_flag[1] && cmp_cfg[33]);
  endfunction

  task automatic chk(input string tag, input logic [1:0] ef, input logic ei);
    tests++;
    if (cmp_flag !== ef || irq !== ei) begin
      fails++;
      $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b", tag, cmp_flag, irq, ef, ei);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [11:0] d,
                      input logic [4:0] ch, input logic [1:0] clr);
    res_vld = v; res_data = d; res_ch = ch; flag_clr = clr;
    @(posedge clk); @(negedge clk);
    res_vld = 0; flag_clr = 0;
    chk(tag, m_flag, m_irq());
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'b00, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 2'b00, 1'b0);

    // R5 R2: unit0, cond 0, ch 3, count 2 -> third consecutive match sets
    cmp_cfg[31:0] = mk(12'h800, 4'd2, 5'd3, 1'b0, 1'b0, 1'b1);
    step("R3 match1", 1, 12'h7FF, 5'd3, 0);
    step("R3 match2", 1, 12'h000, 5'd3, 0);
    step("R2 other channel", 1, 12'hFFF, 5'd5, 0);
    chk("R2 no set", 2'b00, 1'b0);
    step("R5 match3", 1, 12'h123, 5'd3, 0);
    chk("R5 literal", 2'b01, 1'b0);
    step("R7 frozen", 1, 12'h001, 5'd3, 0);
    step("R7 clear", 0, 0, 5'd0, 2'b01);
    chk("R7 literal clear", 2'b00, 1'b0);
    // R6: non-match resets run
    step("R6 m1", 1, 12'h100, 5'd3, 0);
    step("R6 m2", 1, 12'h100, 5'd3, 0);
    step("R6 equal no match R3", 1, 12'h800, 5'd3, 0);
    step("R6 m1b", 1, 12'h100, 5'd3, 0);
    chk("R6 literal", 2'b00, 1'b0);
    step("R6 m2b", 1, 12'h100, 5'd3, 0);
    step("R6 m3b", 1, 12'h100, 5'd3, 0);
    chk("R6 literal set", 2'b01, 1'b0);
    step("R7 clr", 0, 0, 0, 2'b01);
    // R9: disable clears counter
    step("R9 m1", 1, 12'h100, 5'd3, 0);
    step("R9 m2", 1, 12'h100, 5'd3, 0);
    cmp_cfg[0] = 0;
    step("R9 off", 0, 0, 0, 0);
    cmp_cfg[0] = 1;
    step("R9 m1c", 1, 12'h100, 5'd3, 0);
    chk("R9 literal", 2'b00, 1'b0);
    // R4 R5 R8 R10: unit1 cond 1, equal matches, count 0, irq on
    cmp_cfg[63:32] = mk(12'h400, 4'd0, 5'd17, 1'b1, 1'b1, 1'b1);
    step("R4 below", 1, 12'h3FF, 5'd17, 0);
    chk("R4 below literal", 2'b00, 1'b0);
    step("R4 equal", 1, 12'h400, 5'd17, 0);
    chk("R8 R10 literal", 2'b10, 1'b1);
    cmp_cfg[33] = 0;
    @(negedge clk);
    chk("R8 ie off", 2'b10, 1'b0);
    step("R7 clr1", 0, 0, 0, 2'b10);

    for (int k = 0; k < 4000; k++) begin
      if (k % 300 == 0) begin
        cmp_cfg[31:0]  = mk(12'h7F0 + 12'($urandom_range(0, 32)), 4'($urandom_range(0, 3)),
                            5'd3, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) != 0));
        cmp_cfg[63:32] = mk(12'h7F0 + 12'($urandom_range(0, 32)), 4'($urandom_range(0, 3)),
                            5'd17, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) != 0));
      end
      if ($urandom_range(0, 99) == 0) cmp_cfg[0] = ~cmp_cfg[0];
      step("R10 random", 1'($urandom_range(0, 3) != 0),
           12'h7E0 + 12'($urandom_range(0, 64)),
           ($urandom_range(0, 2) == 0) ? 5'd9 : (($urandom & 1) ? 5'd3 : 5'd17),
           ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule